// File: doc/BRIEF.md
# Saturating Multi-Operation Arithmetic Unit

A purely combinational datapath for signed two's-complement operands. A three-bit operation code picks one of six functions: sum, difference, average rounded upward, magnitude of the second operand, signed maximum, and magnitude of the difference. All six share one adder one bit wider than the operands. The operand stage swaps, zeroes or inverts the inputs and sets the carry-in. The result stage picks, halves or clamps the adder output.

Every function whose true answer can leave the signed range of `W` bits is clamped to the nearest bound. A separate flag reports when that clamp replaced the true answer. The average and the maximum are formed from the widened sum or difference, so they cannot go out of range. The block has no clock and no state: the result follows the inputs within the same cycle.

Top module: `sau_top`

## Requirements
- R1: With `op` = 0 the result is `a + b`; if the signed sum exceeds 2^(W-1)-1 the result is 2^(W-1)-1 (8'h7F for W=8) and `ovf` = 1, if below -2^(W-1) the result is -2^(W-1) (8'h80) and `ovf` = 1, otherwise `ovf` = 0.
- R2: With `op` = 1 the result is `a - b`, clamped and flagged in the same way as R1.
- R3: With `op` = 2 the result is floor((a + b + 1) / 2) over the signed values, which always fits, and `ovf` is always 0.
- R4: With `op` = 3 the result is the absolute value of `b`; for `b` = -2^(W-1) the result is 2^(W-1)-1 with `ovf` = 1, otherwise `ovf` = 0.
- R5: With `op` = 4 the result is the signed larger of `a` and `b`, correct even where `a - b` does not fit in W bits, with `ovf` = 0.
- R6: With `op` = 5 the result is |b - a|; a magnitude of exactly 2^(W-1)-1 passes with `ovf` = 0, and any larger magnitude gives 2^(W-1)-1 with `ovf` = 1.
- R7: With `op` = 6 or 7 the result is 0 and `ovf` is 0.
- R8: With `op` = 3, the value of `a` has no effect on `result` or `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First signed operand |
| b | input | W | Second signed operand |
| op | input | 3 | Operation code (0 sum, 1 difference, 2 average, 3 magnitude of b, 4 maximum, 5 magnitude of difference, 6 and 7 zero) |
| result | output | W | Signed result, clamped where the operation calls for it |
| ovf | output | 1 | High when the result was clamped |

## Verification
The bench builds the unit with the default width of eight bits. At that width every clamp boundary can be written down by hand: sums that hit +127 or -128, magnitude of -128, a difference of exactly 127 against one of 128, and averages of the two extreme pairs. The width is also small enough to sweep a dense grid of operand pairs through every operation code against an integer model in a few tens of thousands of cycles.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AVG = 3'd2,
        OP_ABS = 3'd3,
        OP_MAX = 3'd4,
        OP_ADF = 3'd5,
        OP_NU6 = 3'd6,
        OP_NU7 = 3'd7
    } sau_op_e;

    // Operand steering for the shared adder
    typedef struct packed {
        logic x_zero;   // drive zero on the x leg
        logic swap;     // x takes b, y takes a
        logic inv_y;    // one's complement of the y leg
        logic cin;      // carry into the adder
    } sau_ctl_t;

    // How the result stage treats the widened adder output
    typedef enum logic [2:0] {
        RS_SAT  = 3'd0,   // clamp on signed overflow
        RS_HALF = 3'd1,   // drop the lowest bit
        RS_ABS  = 3'd2,   // pass b or its negation, clamp -min
        RS_MAX  = 3'd3,   // choose by sign of difference
        RS_ADF  = 3'd4,   // magnitude then clamp
        RS_ZERO = 3'd5
    } sau_rsel_e;

    function automatic sau_ctl_t op_ctl(input logic [2:0] code);
        sau_ctl_t c;
        c = '{x_zero: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: 1'b0};
        case (code)
            OP_ADD: c = '{x_zero: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: 1'b0};
            OP_SUB: c = '{x_zero: 1'b0, swap: 1'b0, inv_y: 1'b1, cin: 1'b1};
            OP_AVG: c = '{x_zero: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: 1'b1};
            OP_ABS: c = '{x_zero: 1'b1, swap: 1'b0, inv_y: 1'b1, cin: 1'b1};
            OP_MAX: c = '{x_zero: 1'b0, swap: 1'b0, inv_y: 1'b1, cin: 1'b1};
            OP_ADF: c = '{x_zero: 1'b0, swap: 1'b1, inv_y: 1'b1, cin: 1'b1};
            default: c = '{x_zero: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: 1'b0};
        endcase
        return c;
    endfunction

    function automatic sau_rsel_e op_rsel(input logic [2:0] code);
        sau_rsel_e r;
        case (code)
            OP_ADD, OP_SUB: r = RS_SAT;
            OP_AVG:         r = RS_HALF;
            OP_ABS:         r = RS_ABS;
            OP_MAX:         r = RS_MAX;
            OP_ADF:         r = RS_ADF;
            default:        r = RS_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sau_opnd.sv
module sau_opnd
    import sau_pkg::*;
#(
    parameter int W = 8
) (
    input  sau_ctl_t   ctl,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   x,
    output logic [W:0]   y,
    output logic         cin
);
    localparam int XW = W + 1;

    logic [XW-1:0] a_ext;
    logic [XW-1:0] b_ext;
    logic [XW-1:0] y_raw;

    always_comb begin
        a_ext = {a[W-1], a};
        b_ext = {b[W-1], b};
        if (ctl.x_zero) begin
            x = '0;
        end else if (ctl.swap) begin
            x = b_ext;
        end else begin
            x = a_ext;
        end
        y_raw = ctl.swap ? a_ext : b_ext;
        y     = ctl.inv_y ? ~y_raw : y_raw;
        cin   = ctl.cin;
    end

endmodule

// File: rtl/sau_addr.sv
module sau_addr #(
    parameter int W = 8
) (
    input  logic [W:0] x,
    input  logic [W:0] y,
    input  logic       cin,
    output logic [W:0] sum
);
    // The single carry-propagate adder of the unit
    always_comb begin
        sum = x + y + {{W{1'b0}}, cin};
    end

endmodule

// File: rtl/sau_incr.sv
module sau_incr #(
    parameter int N = 9
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    // Half-adder chain adding one; carry out of the top bit is dropped
    logic [N-1:0] c;

    assign c[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_ha
        assign dout[i] = din[i] ^ c[i];
        if (i < N - 1) begin : g_carry
            assign c[i+1] = din[i] & c[i];
        end
    end

endmodule

// File: rtl/sau_rsel.sv
module sau_rsel
    import sau_pkg::*;
#(
    parameter int W = 8
) (
    input  sau_rsel_e    sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W:0]   sum,
    output logic [W-1:0] result,
    output logic         ovf
);
    localparam int XW = W + 1;
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [XW-1:0] sum_n;
    logic [XW-1:0] neg;
    logic [XW-1:0] mag;

    assign sum_n = ~sum;

    sau_incr #(.N(XW)) u_negate (
        .din  (sum_n),
        .dout (neg)
    );

    always_comb begin
        mag    = sum[W] ? neg : sum;
        result = '0;
        ovf    = 1'b0;
        case (sel)
            RS_SAT: begin
                if (sum[W] != sum[W-1]) begin
                    ovf    = 1'b1;
                    result = sum[W] ? NEG_MIN : POS_MAX;
                end else begin
                    result = sum[W-1:0];
                end
            end
            RS_HALF: begin
                result = sum[W:1];
            end
            RS_ABS: begin
                if (!b[W-1]) begin
                    result = b;
                end else if (sum[W-1]) begin
                    ovf    = 1'b1;
                    result = POS_MAX;
                end else begin
                    result = sum[W-1:0];
                end
            end
            RS_MAX: begin
                result = sum[W] ? b : a;
            end
            RS_ADF: begin
                if (mag[W] | mag[W-1]) begin
                    ovf    = 1'b1;
                    result = POS_MAX;
                end else begin
                    result = mag[W-1:0];
                end
            end
            default: begin
                result = '0;
                ovf    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sau_top.sv
module sau_top
    import sau_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] result,
    output logic         ovf
);
    localparam int XW = W + 1;

    sau_ctl_t      ctl;
    sau_rsel_e     rsel;
    logic [XW-1:0] x;
    logic [XW-1:0] y;
    logic          cin;
    logic [XW-1:0] sum;

    always_comb begin
        ctl  = op_ctl(op);
        rsel = op_rsel(op);
    end

    sau_opnd #(.W(W)) u_opnd (
        .ctl (ctl),
        .a   (a),
        .b   (b),
        .x   (x),
        .y   (y),
        .cin (cin)
    );

    sau_addr #(.W(W)) u_addr (
        .x   (x),
        .y   (y),
        .cin (cin),
        .sum (sum)
    );

    sau_rsel #(.W(W)) u_rsel (
        .sel    (rsel),
        .a      (a),
        .b      (b),
        .sum    (sum),
        .result (result),
        .ovf    (ovf)
    );

endmodule

// File: rtl/sau_chk.sv
module sau_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [2:0]   op,
    input logic [W-1:0] result,
    input logic         ovf
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        // R1: a clamped sum sits on a bound whose sign matches the operands
        p_sat_bounds_r1: assert (!(op == 3'd0 && ovf) ||
                                 (result == POS_MAX && !a[W-1] && !b[W-1]) ||
                                 (result == NEG_MIN && a[W-1] && b[W-1]))
            else $error("r1 clamp bound");
        // R2: a clamped difference sits on a bound set by the sign of a
        p_sub_bounds_r2: assert (!(op == 3'd1 && ovf) ||
                                 (result == POS_MAX && !a[W-1]) ||
                                 (result == NEG_MIN && a[W-1]))
            else $error("r2 clamp bound");
        // R3: the average never flags
        p_no_overflow_r3: assert (!(op == 3'd2) || !ovf)
            else $error("r3 flag on average");
        // R4: magnitude of b is never negative
        p_abs_nonneg_r4: assert (!(op == 3'd3) || !result[W-1])
            else $error("r4 negative magnitude");
        // R5: maximum is one of the operands and never flags
        p_max_member_r5: assert (!(op == 3'd4) ||
                                 ((result == a || result == b) && !ovf))
            else $error("r5 maximum not an operand");
        // R6: magnitude of the difference is never negative
        p_adf_nonneg_r6: assert (!(op == 3'd5) || !result[W-1])
            else $error("r6 negative magnitude");
        // R7: spare codes give zero and no flag
        p_unused_zero_r7: assert (!(op[2:1] == 2'b11) || (result == '0 && !ovf))
            else $error("r7 spare code not zero");
    end

endmodule

bind sau_top sau_chk #(.W(W)) u_chk (
    .a      (a),
    .b      (b),
    .op     (op),
    .result (result),
    .ovf    (ovf)
);

// File: tb/tb_sau_top.sv
module tb_sau_top;

    localparam int WB = 8;
    localparam int STRIDE = 5;

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] r;
        logic       o;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 3'd0, 8'h0A, 8'h14, 8'h1E, 1'b0},  // R1 plain sum
        '{4'd1, 3'd0, 8'h64, 8'h32, 8'h7F, 1'b1},  // R1 positive clamp
        '{4'd1, 3'd0, 8'h9C, 8'hCE, 8'h80, 1'b1},  // R1 negative clamp
        '{4'd1, 3'd0, 8'h7F, 8'h00, 8'h7F, 1'b0},  // R1 at bound, no clamp
        '{4'd2, 3'd1, 8'h05, 8'h09, 8'hFC, 1'b0},  // R2 plain difference
        '{4'd2, 3'd1, 8'h80, 8'h01, 8'h80, 1'b1},  // R2 negative clamp
        '{4'd2, 3'd1, 8'h7F, 8'hFF, 8'h7F, 1'b1},  // R2 positive clamp
        '{4'd3, 3'd2, 8'h03, 8'h04, 8'h04, 1'b0},  // R3 round up
        '{4'd3, 3'd2, 8'hFD, 8'hFC, 8'hFD, 1'b0},  // R3 negative pair
        '{4'd3, 3'd2, 8'h7F, 8'h7F, 8'h7F, 1'b0},  // R3 top extreme
        '{4'd3, 3'd2, 8'h80, 8'h80, 8'h80, 1'b0},  // R3 bottom extreme
        '{4'd3, 3'd2, 8'hFF, 8'h00, 8'h00, 1'b0},  // R3 half rounds to zero
        '{4'd4, 3'd3, 8'h00, 8'h80, 8'h7F, 1'b1},  // R4 most negative
        '{4'd4, 3'd3, 8'h55, 8'hF6, 8'h0A, 1'b0},  // R4 negative input
        '{4'd4, 3'd3, 8'h12, 8'h21, 8'h21, 1'b0},  // R4 positive input
        '{4'd5, 3'd4, 8'h7F, 8'h80, 8'h7F, 1'b0},  // R5 difference overflows
        '{4'd5, 3'd4, 8'h80, 8'h05, 8'h05, 1'b0},  // R5 b larger
        '{4'd5, 3'd4, 8'hF0, 8'hF1, 8'hF1, 1'b0},  // R5 both negative
        '{4'd6, 3'd5, 8'h80, 8'h7F, 8'h7F, 1'b1},  // R6 widest gap
        '{4'd6, 3'd5, 8'h10, 8'h03, 8'h0D, 1'b0},  // R6 a larger
        '{4'd6, 3'd5, 8'h9C, 8'h1B, 8'h7F, 1'b0},  // R6 exactly 127
        '{4'd6, 3'd5, 8'h9C, 8'h1C, 8'h7F, 1'b1},  // R6 just past 127
        '{4'd7, 3'd6, 8'h12, 8'h34, 8'h00, 1'b0}   // R7 spare code six
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WB-1:0] a   = '0;
    logic [WB-1:0] b   = '0;
    logic [2:0]    op  = '0;
    logic [WB-1:0] result;
    logic          ovf;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    sau_top #(.W(WB)) dut (
        .a      (a),
        .b      (b),
        .op     (op),
        .result (result),
        .ovf    (ovf)
    );

    function automatic void ref_model(input logic [2:0] c, input logic [7:0] va,
                                      input logic [7:0] vb, output logic [7:0] r,
                                      output logic o);
        int sa;
        int sb;
        int t;
        sa = $signed(va);
        sb = $signed(vb);
        o  = 1'b0;
        case (c)
            3'd0: t = sa + sb;                    // R1
            3'd1: t = sa - sb;                    // R2
            3'd2: t = (sa + sb + 1) >>> 1;        // R3
            3'd3: t = (sb < 0) ? -sb : sb;        // R4
            3'd4: t = (sa > sb) ? sa : sb;        // R5
            3'd5: begin                           // R6
                t = sb - sa;
                if (t < 0) t = -t;
            end
            default: t = 0;                       // R7
        endcase
        if (t > 127) begin
            t = 127;
            o = 1'b1;
        end else if (t < -128) begin
            t = -128;
            o = 1'b1;
        end
        r = t[7:0];
    endfunction

    task automatic drive(input logic [2:0] c, input logic [7:0] va, input logic [7:0] vb);
        @(negedge clk);
        op = c;
        a  = va;
        b  = vb;
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] er, input logic eo);
        checks++;
        if (result !== er || ovf !== eo) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h: got result=%h ovf=%b expected result=%h ovf=%b",
                     req, op, a, b, result, ovf, er, eo);
        end
    endtask

    initial begin
        logic [7:0] er;
        logic       eo;
        logic [7:0] keep_r;
        logic       keep_o;

        repeat (4) @(posedge clk);
        rst = 1'b0;

        // Idle state: zero operands on code 0 give zero, no flag (R1)
        @(negedge clk);
        #1;
        chk("R1 idle", 8'h00, 1'b0);

        // Table of hand-worked corners
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].a, VEC[i].b);
            chk($sformatf("R%0d table %0d", VEC[i].req, i), VEC[i].r, VEC[i].o);
        end

        // R7 code seven with extreme operands
        drive(3'd7, 8'h7F, 8'h7F);
        chk("R7 code seven", 8'h00, 1'b0);

        // R8: a has no effect on the magnitude of b
        drive(3'd3, 8'h00, 8'h80);
        keep_r = result;
        keep_o = ovf;
        for (int v = 1; v < 256; v += 37) begin
            drive(3'd3, v[7:0], 8'h80);
            chk("R8 a ignored, b=80", keep_r, keep_o);
        end
        drive(3'd3, 8'h7F, 8'hC3);
        keep_r = result;
        drive(3'd3, 8'h80, 8'hC3);
        chk("R8 a ignored, b=C3", keep_r, 1'b0);

        // Grid sweep against the integer model, every code
        for (int c = 0; c < 8; c++) begin
            for (int ia = 0; ia < 256; ia += STRIDE) begin
                for (int ib = 0; ib < 256; ib += STRIDE) begin
                    drive(c[2:0], ia[7:0], ib[7:0]);
                    ref_model(c[2:0], ia[7:0], ib[7:0], er, eo);
                    case (c)
                        0: chk("R1 sweep", er, eo);
                        1: chk("R2 sweep", er, eo);
                        2: chk("R3 sweep", er, eo);
                        3: chk("R4 sweep", er, eo);
                        4: chk("R5 sweep", er, eo);
                        5: chk("R6 sweep", er, eo);
                        default: chk("R7 sweep", er, eo);
                    endcase
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule